// File: doc/BRIEF.md
# Configuration EEPROM Autoloader

This block fills the switch's configuration registers from a small serial EEPROM once reset has been released. It does not drive the 2-wire bus. Instead it asks a separate byte-read engine for one address at a time through a request/acknowledge port. Address 0 of the EEPROM gives the last address to fetch. Every byte after it is decoded against a fixed map:

- the aging time;
- VLAN membership masks for ports 0 to 4;
- the flooding destination of each port;
- the broadcast, pause-on and pause-off thresholds;
- the disabled-port mask;
- a system-control byte;
- a list of static MAC entries.

Each static entry takes seven bytes. It leaves the block as a one-cycle write pulse that carries the MAC address and the port.

Two straps are sampled in the first clock cycle after reset: interface enable and autoload enable. Unless both are 1, the block makes no reads and marks itself done at once. In that case, and for every address the walk never reaches, the registers keep their reset defaults. A flooding selector with a forbidden value is replaced by "flood to all" and a sticky error flag is raised.

Top module: `cfg_autoload`

## Requirements
- R1: When either strap sampled in the first cycle after reset is 0, no read is requested, `done_o` rises on the following cycle, and every output register holds its reset default.
- R2: With both straps at 1, the first read is at address 0x00. The byte returned there is the end address E. The reads that follow are at 0x01, 0x02 and so on up to E, in ascending order, and no address above E is ever requested. If E is 0, only address 0 is read.
- R3: `aging_time_o` is {byte 0x02, byte 0x01}. Its default is 0x012C.
- R4: `vlan_mask_o[8p+7:8p]` is taken from byte 0x03+p for ports p = 0 to 4. The default is all ones except bit p.
- R5: `flood_sel_o[4p+3:4p]` is taken from byte 0x0B + p/2. Even ports use the low nibble and odd ports the high nibble. The high nibble of 0x0D is ignored. The default is 0xF for port 0 and 0x0 for the other ports.
- R6: A flooding nibble in the range 0x8 to 0xE is stored as 0xF and sets `cfg_err_o`. Once set, `cfg_err_o` stays at 1 until reset.
- R7: Five bytes load single settings, each with its own default:

  | Byte | Output | Default |
  |---|---|---|
  | 0x0F | `bcast_th_o` | 0xFF |
  | 0x10 | `xon_th_o` | 0x74 |
  | 0x11 | `xoff_th_o` | 0x30 |
  | 0x12 | `port_dis_o` | 0x00 |
  | 0x13 | `sys_ctl_o` (bit 0 is enhanced back pressure) | 0x00 |

- R8: Record k occupies bytes B = 0x20+7k to B+6. Bytes B to B+5 form MAC[7:0] up to MAC[47:40], and bits [2:0] of byte B+6 form the port. The entry is emitted as a single-cycle `st_valid_o` pulse in the cycle after byte B+6 is acknowledged. Records come out in ascending order.
- R9: A record that ends beyond E is not emitted.
- R10: Each register whose address is 0 or greater than E keeps its default.
- R11: `done_o` rises exactly one cycle after the final byte is acknowledged and then stays high. No request is made while `done_o` is high.
- R12: While `rd_req_o` is high and `rd_ack_i` is low, the request and its address stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_eeif_i | input | 1 | EEPROM interface enable strap |
| strap_auto_i | input | 1 | Autoload enable strap |
| rd_req_o | output | 1 | Byte-read request |
| rd_addr_o | output | 8 | Address of the requested byte |
| rd_ack_i | input | 1 | Read done; `rd_data_i` is valid in this cycle |
| rd_data_i | input | 8 | Byte returned by the read |
| aging_time_o | output | 16 | Aging time |
| vlan_mask_o | output | 40 | VLAN masks for ports 0 to 4, 8 bits each |
| flood_sel_o | output | 20 | Flooding selectors for ports 0 to 4, 4 bits each |
| bcast_th_o | output | 8 | Broadcast threshold |
| xon_th_o | output | 8 | Pause-on threshold |
| xoff_th_o | output | 8 | Pause-off threshold |
| port_dis_o | output | 8 | Disabled-port mask |
| sys_ctl_o | output | 8 | System-control byte |
| st_valid_o | output | 1 | Static-entry write pulse |
| st_mac_o | output | 48 | Static-entry MAC address |
| st_port_o | output | 3 | Static-entry port |
| cfg_err_o | output | 1 | Sticky flag for a forbidden flooding value |
| done_o | output | 1 | Loading finished |

## Verification
Two events can fall in the same cycle: the write pulse for a static record and the rise of `done_o`. This happens when the end address is exactly the seventh byte of a record. The sweep of end addresses covers every position in a record, including 0x26 and 0x2D. In each run the bench counts the emitted records against the number of complete records at or below the end address. It also confirms that `done_o` was low when the final byte was granted and high one cycle later. A second pairing is a forbidden flooding nibble arriving together with a valid one in the same byte. The nibble sweep judges both the substituted value and the error flag.

// File: rtl/cfg_autoload_pkg.sv
package cfg_autoload_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned REC_BYTES = 7;
  localparam int unsigned MAC_BYTES = 6;

  localparam logic [7:0] A_AGE_LO      = 8'h01;
  localparam logic [7:0] A_AGE_HI      = 8'h02;
  localparam logic [7:0] A_VLAN_BASE   = 8'h03;
  localparam logic [7:0] A_FLOOD_BASE  = 8'h0B;
  localparam logic [7:0] A_BCAST       = 8'h0F;
  localparam logic [7:0] A_XON         = 8'h10;
  localparam logic [7:0] A_XOFF        = 8'h11;
  localparam logic [7:0] A_PDIS        = 8'h12;
  localparam logic [7:0] A_SYSCTL      = 8'h13;
  localparam logic [7:0] A_STATIC_BASE = 8'h20;

  localparam logic [15:0] DEF_AGING  = 16'h012C;
  localparam logic [7:0]  DEF_BCAST  = 8'hFF;
  localparam logic [7:0]  DEF_XON    = 8'h74;
  localparam logic [7:0]  DEF_XOFF   = 8'h30;
  localparam logic [7:0]  DEF_PDIS   = 8'h00;
  localparam logic [7:0]  DEF_SYSCTL = 8'h00;
  localparam logic [3:0]  FLOOD_ALL  = 4'hF;

  typedef enum logic [1:0] {FS_STRAP, FS_EOB, FS_READ, FS_DONE} fetch_state_e;

  function automatic logic nib_forbidden(input logic [3:0] n);
    return (n >= 4'h8) && (n <= 4'hE);
  endfunction
endpackage

// File: rtl/cfg_fetch.sv
module cfg_fetch
  import cfg_autoload_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strap_eeif_i,
  input  logic          strap_auto_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [AW-1:0] rd_data_i,
  output logic          byte_vld_o,
  output logic [AW-1:0] byte_addr_o,
  output logic [AW-1:0] byte_data_o,
  output logic          done_o
);
  fetch_state_e  state_q;
  logic [AW-1:0] addr_q, eob_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_STRAP;
      addr_q  <= '0;
      eob_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        FS_STRAP: begin
          if (strap_eeif_i && strap_auto_i) begin
            state_q <= FS_EOB;
            addr_q  <= '0;
          end else begin
            state_q <= FS_DONE;
            done_q  <= 1'b1;
          end
        end
        FS_EOB: begin
          if (rd_ack_i) begin
            eob_q <= rd_data_i;
            if (rd_data_i == '0) begin
              state_q <= FS_DONE;
              done_q  <= 1'b1;
            end else begin
              addr_q  <= AW'(1);
              state_q <= FS_READ;
            end
          end
        end
        FS_READ: begin
          if (rd_ack_i) begin
            if (addr_q == eob_q) begin
              state_q <= FS_DONE;
              done_q  <= 1'b1;
            end else begin
              addr_q <= addr_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_req_o    = (state_q == FS_EOB) || (state_q == FS_READ);
  assign rd_addr_o   = addr_q;
  assign byte_vld_o  = (state_q == FS_READ) && rd_ack_i;
  assign byte_addr_o = addr_q;
  assign byte_data_o = rd_data_i;
  assign done_o      = done_q;

  a_r12_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

  a_r2_within_eob: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FS_READ) |-> (rd_addr_o <= eob_q && rd_addr_o != '0));

  a_r11_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  a_r11_quiet_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_req_o);
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_autoload_pkg::*;
#(
  parameter int unsigned NP     = 5,
  parameter int unsigned MASK_W = 8,
  parameter int unsigned AW     = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               byte_vld_i,
  input  logic [AW-1:0]      byte_addr_i,
  input  logic [AW-1:0]      byte_data_i,
  output logic [15:0]        aging_time_o,
  output logic [NP*MASK_W-1:0] vlan_mask_o,
  output logic [NP*4-1:0]    flood_sel_o,
  output logic [7:0]         bcast_th_o,
  output logic [7:0]         xon_th_o,
  output logic [7:0]         xoff_th_o,
  output logic [7:0]         port_dis_o,
  output logic [7:0]         sys_ctl_o,
  output logic               cfg_err_o
);
  logic [NP-1:0] flood_bad;
  logic          err_q;

  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam logic [MASK_W-1:0] VDEF = ~(MASK_W'(1) << p);
    localparam logic [3:0]        FDEF = (p == 0) ? FLOOD_ALL : 4'h0;
    logic [MASK_W-1:0] mask_q;
    logic [3:0]        flood_q;
    logic [3:0]        nib;
    logic              vlan_hit, flood_hit;

    assign vlan_hit  = byte_vld_i && (byte_addr_i == AW'(A_VLAN_BASE + p));
    assign flood_hit = byte_vld_i && (byte_addr_i == AW'(A_FLOOD_BASE + p / 2));

    if (p % 2 == 1) begin : g_odd
      assign nib = byte_data_i[7:4];
    end else begin : g_even
      assign nib = byte_data_i[3:0];
    end

    assign flood_bad[p] = flood_hit && nib_forbidden(nib);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q  <= VDEF;
        flood_q <= FDEF;
      end else begin
        if (vlan_hit)  mask_q  <= MASK_W'(byte_data_i);
        if (flood_hit) flood_q <= flood_bad[p] ? FLOOD_ALL : nib;
      end
    end

    assign vlan_mask_o[p*MASK_W +: MASK_W] = mask_q;
    assign flood_sel_o[p*4 +: 4]           = flood_q;

    a_r6_substitute: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flood_bad[p] |=> (cfg_err_o && flood_sel_o[p*4 +: 4] == FLOOD_ALL));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aging_time_o <= DEF_AGING;
      bcast_th_o   <= DEF_BCAST;
      xon_th_o     <= DEF_XON;
      xoff_th_o    <= DEF_XOFF;
      port_dis_o   <= DEF_PDIS;
      sys_ctl_o    <= DEF_SYSCTL;
      err_q        <= 1'b0;
    end else begin
      if (|flood_bad) err_q <= 1'b1;
      if (byte_vld_i) begin
        case (byte_addr_i)
          AW'(A_AGE_LO): aging_time_o[7:0]  <= 8'(byte_data_i);
          AW'(A_AGE_HI): aging_time_o[15:8] <= 8'(byte_data_i);
          AW'(A_BCAST):  bcast_th_o         <= 8'(byte_data_i);
          AW'(A_XON):    xon_th_o           <= 8'(byte_data_i);
          AW'(A_XOFF):   xoff_th_o          <= 8'(byte_data_i);
          AW'(A_PDIS):   port_dis_o         <= 8'(byte_data_i);
          AW'(A_SYSCTL): sys_ctl_o          <= 8'(byte_data_i);
          default: ;
        endcase
      end
    end
  end

  assign cfg_err_o = err_q;

  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);
endmodule

// File: rtl/cfg_static_asm.sv
module cfg_static_asm
  import cfg_autoload_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned PID_W = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        byte_vld_i,
  input  logic [AW-1:0]               byte_addr_i,
  input  logic [AW-1:0]               byte_data_i,
  output logic                        st_valid_o,
  output logic [MAC_BYTES*BYTE_W-1:0] st_mac_o,
  output logic [PID_W-1:0]            st_port_o
);
  localparam int unsigned MAC_W = MAC_BYTES * BYTE_W;
  localparam int unsigned OFF_W = $clog2(REC_BYTES);

  logic [OFF_W-1:0] off_q;
  logic [MAC_W-1:0] mac_q;
  logic             in_rec;

  assign in_rec = byte_vld_i && (byte_addr_i >= AW'(A_STATIC_BASE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q      <= '0;
      mac_q      <= '0;
      st_valid_o <= 1'b0;
      st_mac_o   <= '0;
      st_port_o  <= '0;
    end else begin
      st_valid_o <= 1'b0;
      if (in_rec) begin
        if (off_q == OFF_W'(REC_BYTES - 1)) begin
          off_q      <= '0;
          st_valid_o <= 1'b1;
          st_mac_o   <= mac_q;
          st_port_o  <= byte_data_i[PID_W-1:0];
        end else begin
          mac_q[int'(off_q)*BYTE_W +: BYTE_W] <= BYTE_W'(byte_data_i);
          off_q <= off_q + 1'b1;
        end
      end
    end
  end

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_o |=> !st_valid_o);

  a_r8_aligned_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && byte_addr_i == AW'(A_STATIC_BASE)) |-> (off_q == '0));
endmodule

// File: rtl/cfg_autoload.sv
module cfg_autoload
  import cfg_autoload_pkg::*;
#(
  parameter int unsigned NP     = 5,
  parameter int unsigned MASK_W = 8,
  parameter int unsigned AW     = 8,
  parameter int unsigned PID_W  = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   strap_eeif_i,
  input  logic                   strap_auto_i,
  output logic                   rd_req_o,
  output logic [AW-1:0]          rd_addr_o,
  input  logic                   rd_ack_i,
  input  logic [AW-1:0]          rd_data_i,
  output logic [15:0]            aging_time_o,
  output logic [NP*MASK_W-1:0]   vlan_mask_o,
  output logic [NP*4-1:0]        flood_sel_o,
  output logic [7:0]             bcast_th_o,
  output logic [7:0]             xon_th_o,
  output logic [7:0]             xoff_th_o,
  output logic [7:0]             port_dis_o,
  output logic [7:0]             sys_ctl_o,
  output logic                   st_valid_o,
  output logic [MAC_BYTES*BYTE_W-1:0] st_mac_o,
  output logic [PID_W-1:0]       st_port_o,
  output logic                   cfg_err_o,
  output logic                   done_o
);
  logic          byte_vld;
  logic [AW-1:0] byte_addr, byte_data;

  cfg_fetch #(.AW(AW)) u_fetch (
    .clk_i, .rst_ni, .strap_eeif_i, .strap_auto_i,
    .rd_req_o, .rd_addr_o, .rd_ack_i, .rd_data_i,
    .byte_vld_o(byte_vld), .byte_addr_o(byte_addr), .byte_data_o(byte_data),
    .done_o
  );

  cfg_regs #(.NP(NP), .MASK_W(MASK_W), .AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .byte_vld_i(byte_vld), .byte_addr_i(byte_addr), .byte_data_i(byte_data),
    .aging_time_o, .vlan_mask_o, .flood_sel_o, .bcast_th_o, .xon_th_o,
    .xoff_th_o, .port_dis_o, .sys_ctl_o, .cfg_err_o
  );

  cfg_static_asm #(.AW(AW), .PID_W(PID_W)) u_static (
    .clk_i, .rst_ni,
    .byte_vld_i(byte_vld), .byte_addr_i(byte_addr), .byte_data_i(byte_data),
    .st_valid_o, .st_mac_o, .st_port_o
  );
endmodule

// File: tb/cfg_autoload_tb_top.sv
`timescale 1ns/1ps
module cfg_autoload_tb_top;
  localparam int NP = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        eeif = 1'b0, autol = 1'b0;
  logic        rd_req, rd_ack = 1'b0;
  logic [7:0]  rd_addr, rd_data = 8'h00;
  logic [15:0] aging;
  logic [NP*8-1:0] vlan;
  logic [NP*4-1:0] flood;
  logic [7:0]  bth, xon, xoff, pdis, sysc;
  logic        st_vld, cerr, done;
  logic [47:0] st_mac;
  logic [2:0]  st_port;

  cfg_autoload dut_i (
    .clk_i(clk), .rst_ni(rst_n), .strap_eeif_i(eeif), .strap_auto_i(autol),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack), .rd_data_i(rd_data),
    .aging_time_o(aging), .vlan_mask_o(vlan), .flood_sel_o(flood),
    .bcast_th_o(bth), .xon_th_o(xon), .xoff_th_o(xoff), .port_dis_o(pdis),
    .sys_ctl_o(sysc), .st_valid_o(st_vld), .st_mac_o(st_mac), .st_port_o(st_port),
    .cfg_err_o(cerr), .done_o(done)
  );

  logic [7:0]  mem [256];
  int          vec = 0, miss = 0;
  int          lat = 0, exp_next = 0, reads = 0, nst = 0, last_addr = 0;
  logic        pend = 1'b0;
  logic [47:0] mac_log [40];
  logic [2:0]  port_log [40];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // byte-read engine model and port monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_ack = 1'b0;
      lat = 0;
    end else begin
      if (pend) begin
        chk("R11 done one cycle after last byte", 64'(done), 64'd1);
        pend = 1'b0;
      end
      if (done && rd_req) chk("R11 request after done", 64'd1, 64'd0);
      if (st_vld && nst < 40) begin
        mac_log[nst] = st_mac;
        port_log[nst] = st_port;
        nst++;
      end
      if (rd_ack) begin
        rd_ack = 1'b0;
      end else if (rd_req) begin
        if (lat >= int'(rd_addr % 3)) begin
          lat = 0;
          if (int'(rd_addr) != exp_next) chk("R2 address order", 64'(rd_addr), 64'(exp_next));
          if (exp_next > 0 && rd_addr > mem[0]) chk("R2 address above end", 64'(rd_addr), 64'(mem[0]));
          exp_next = int'(rd_addr) + 1;
          reads++;
          if (int'(rd_addr) == last_addr) begin
            chk("R11 done low at last grant", 64'(done), 64'd0);
            pend = 1'b1;
          end
          rd_data = mem[rd_addr];
          rd_ack = 1'b1;
        end else begin
          lat++;
        end
      end
    end
  end

  function automatic logic reach(input logic en, input int eob, input int a);
    return en && a != 0 && a <= eob;
  endfunction

  task automatic run_load(input logic se, input logic sa, input int eob, input int seed, input int fmode);
    logic en;
    logic [7:0] v;
    logic [3:0] n;
    logic [3:0] fexp;
    logic ferr;
    int nrec;
    for (int a = 1; a < 256; a++) mem[a] = 8'(a * 37 + seed * 11 + 5);
    mem[0] = 8'(eob);
    if (fmode >= 0) begin
      mem[8'h0B] = {4'(fmode), 4'(fmode) ^ 4'h5};
      mem[8'h0C] = {~4'(fmode), 4'(fmode)};
      mem[8'h0D] = {4'(fmode), 4'(15 - fmode)};
    end
    en = se && sa;
    rst_n = 1'b0;
    eeif = se;
    autol = sa;
    exp_next = 0;
    reads = 0;
    nst = 0;
    pend = 1'b0;
    last_addr = eob;
    repeat (3) @(negedge clk);
    if (se === 1'b1 && sa === 1'b1 && eob == 0 && seed == 1) begin
      chk("R1 reset state done", 64'(done), 64'd0);
      chk("R3 reset aging", 64'(aging), 64'h012C);
    end
    rst_n = 1'b1;
    for (int t = 0; t < 3000 && !done; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R11 done set", 64'(done), 64'd1);
    chk("R1/R2 read count", 64'(reads), en ? 64'(eob + 1) : 64'd0);
    chk("R3 aging", 64'(aging),
        {48'd0, reach(en, eob, 2) ? mem[2] : 8'h01, reach(en, eob, 1) ? mem[1] : 8'h2C});
    ferr = 1'b0;
    for (int p = 0; p < NP; p++) begin
      v = reach(en, eob, 3 + p) ? mem[3 + p] : ~(8'd1 << p);
      chk("R4 vlan mask", 64'(vlan[p*8 +: 8]), 64'(v));
      if (reach(en, eob, 8'h0B + p / 2)) begin
        n = (p % 2 == 1) ? mem[8'h0B + p / 2][7:4] : mem[8'h0B + p / 2][3:0];
        if (n >= 4'h8 && n <= 4'hE) begin
          fexp = 4'hF;
          ferr = 1'b1;
        end else fexp = n;
      end else fexp = (p == 0) ? 4'hF : 4'h0;
      chk("R5 flood select", 64'(flood[p*4 +: 4]), 64'(fexp));
    end
    chk("R6 config error", 64'(cerr), 64'(ferr));
    chk("R7 bcast", 64'(bth), 64'(reach(en, eob, 8'h0F) ? mem[8'h0F] : 8'hFF));
    chk("R7 xon", 64'(xon), 64'(reach(en, eob, 8'h10) ? mem[8'h10] : 8'h74));
    chk("R7 xoff", 64'(xoff), 64'(reach(en, eob, 8'h11) ? mem[8'h11] : 8'h30));
    chk("R10 port disable", 64'(pdis), 64'(reach(en, eob, 8'h12) ? mem[8'h12] : 8'h00));
    chk("R10 system control", 64'(sysc), 64'(reach(en, eob, 8'h13) ? mem[8'h13] : 8'h00));
    nrec = 0;
    if (en) while (8'h20 + 7 * nrec + 6 <= eob) nrec++;
    chk("R9 static record count", 64'(nst), 64'(nrec));
    for (int k = 0; k < nrec && k < nst; k++) begin
      logic [47:0] m;
      int b;
      b = 8'h20 + 7 * k;
      for (int i = 0; i < 6; i++) m[8*i +: 8] = mem[b + i];
      chk("R8 static mac", 64'(mac_log[k]), 64'(m));
      chk("R8 static port", 64'(port_log[k]), 64'(mem[b + 6][2:0]));
    end
  endtask

  initial begin
    run_load(1'b0, 1'b0, 8'h13, 3, -1);
    run_load(1'b0, 1'b1, 8'h13, 4, -1);
    run_load(1'b1, 1'b0, 8'h13, 5, -1);
    run_load(1'b1, 1'b1, 0, 1, -1);
    run_load(1'b1, 1'b1, 8'h13, 1, -1);
    run_load(1'b1, 1'b1, 8'h13, 2, -1);
    for (int f = 0; f < 16; f++) run_load(1'b1, 1'b1, 8'h13, 7, f);
    for (int e = 0; e <= 8'h40; e++) run_load(1'b1, 1'b1, e, e, -1);
    run_load(1'b1, 1'b1, 8'hFF, 9, -1);
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    vec++;
    miss++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule